// File: doc/BRIEF.md
# Boot Region Address Remap Decoder

This block sits on the processor side of an interconnect and decides, for every 32-bit request address, which of four targets receives the access: SDRAM, boot ROM, on-chip RAM, or a pass-through path toward other peripherals. The decision is combinational. It is taken from three small configuration registers that are written and read over a simple register port. The block also produces the address as the chosen target sees it.

A programmable SDRAM window with 1 MB granularity claims one range of addresses and has the highest priority. The lowest megabyte is the boot region. When the window does not cover it, a single remap bit picks whether boot ROM or on-chip RAM appears there. The reset values give the pre-boot map: boot ROM at address zero, and SDRAM filtering enabled from 1 MB up to 3 GB. Boot software later moves the window start to zero so that SDRAM also covers the boot region.

Register offsets on `reg_addr` are: 0 = window start, 1 = window end, 2 = remap, 3 = unused.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset, the window start register reads 0x00100001, the window end register reads 0xC0000000 and the remap register reads 0x00000000.
- R2: Only these bits are stored: start bits [31:20] plus enable bit 0, end bits [31:20], and remap bit 0. Every other bit reads zero. Writing all ones therefore reads back 0xFFF00001, 0xFFF00000 and 0x00000001.
- R3: A register write changes the read value and the decode result from the clock edge that captures it, and not before.
- R4: With filtering enabled (start bit 0 = 1), an address is sent to SDRAM when start[31:20] <= addr[31:20] < end[31:20]. The lower 20 address bits take no part in the comparison. An empty window (start >= end) claims nothing.
- R5: With filtering disabled (start bit 0 = 0), no address selects SDRAM.
- R6: An address with bits [31:20] equal to zero that lies outside the SDRAM window selects boot ROM when remap bit 0 is 0, and on-chip RAM when it is 1.
- R7: When the SDRAM window covers the boot region, the boot region goes to SDRAM whatever the remap bit holds.
- R8: Addresses that match neither the window nor the boot region select pass-through. Exactly one bit of `tgt_sel` is set for every address. The bits are: bit 0 SDRAM, bit 1 boot ROM, bit 2 on-chip RAM, bit 3 pass-through.
- R9: The local address is addr minus {start[31:20], 20'h0} for SDRAM, addr[19:0] zero-extended for boot ROM and on-chip RAM, and addr unchanged for pass-through.
- R10: A write to register offset 3 changes no register, and a read of offset 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` (combinational) |
| req_addr | input | 32 | Request address to decode |
| tgt_sel | output | 4 | One-hot target select |
| tgt_addr | output | 32 | Address local to the selected target |

## Verification
Two functions can meet in the same cycle: a register write that moves the window or flips the remap bit, and a decode of a boot-region address that depends on that register. The bench holds a boot-region address steady while it drives such a write. It checks the select just before the capturing edge, where the old mapping must still hold, and just after it, where the new mapping must hold. Full sweeps over all 4096 megabyte granules, taken under several window and remap settings, judge the priority of the window over the remap bit at every boundary.

// File: rtl/remap_dec_pkg.sv
package remap_dec_pkg;
  localparam int TGT_N = 4;
  typedef enum logic [1:0] {
    TGT_SDRAM = 2'd0,
    TGT_ROM   = 2'd1,
    TGT_RAM   = 2'd2,
    TGT_PASS  = 2'd3
  } tgt_e;
  localparam logic [1:0] RA_START = 2'd0;
  localparam logic [1:0] RA_END   = 2'd1;
  localparam logic [1:0] RA_REMAP = 2'd2;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20,
  parameter logic [ADDR_W-1:0] RST_START = 32'h0010_0001,
  parameter logic [ADDR_W-1:0] RST_END   = 32'hC000_0000,
  parameter logic RST_REMAP = 1'b0,
  localparam int HI_W = ADDR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic [HI_W-1:0]   start_hi,
  output logic              filt_en,
  output logic [HI_W-1:0]   end_hi,
  output logic              remap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_hi <= RST_START[ADDR_W-1:GRAN_W];
      filt_en  <= RST_START[0];
      end_hi   <= RST_END[ADDR_W-1:GRAN_W];
      remap    <= RST_REMAP;
    end else if (we) begin
      case (addr)
        RA_START: begin
          start_hi <= wdata[ADDR_W-1:GRAN_W];
          filt_en  <= wdata[0];
        end
        RA_END:   end_hi <= wdata[ADDR_W-1:GRAN_W];
        RA_REMAP: remap  <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_START: rdata = {start_hi, {(GRAN_W-1){1'b0}}, filt_en};
      RA_END:   rdata = {end_hi, {GRAN_W{1'b0}}};
      RA_REMAP: rdata = {{(ADDR_W-1){1'b0}}, remap};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/remap_window_cmp.sv
module remap_window_cmp #(
  parameter int HI_W = 12
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] start_hi,
  input  logic [HI_W-1:0] end_hi,
  input  logic            filt_en,
  output logic            in_win,
  output logic            in_boot
);
  logic ge_start, lt_end;
  assign ge_start = (addr_hi >= start_hi);
  assign lt_end   = (addr_hi < end_hi);
  assign in_win   = filt_en & ge_start & lt_end;
  assign in_boot  = (addr_hi == '0);
endmodule

// File: rtl/remap_target_sel.sv
module remap_target_sel
  import remap_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20,
  localparam int HI_W = ADDR_W - GRAN_W
) (
  input  logic              in_win,
  input  logic              in_boot,
  input  logic              remap,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   start_hi,
  output logic [TGT_N-1:0]  sel,
  output logic [ADDR_W-1:0] local_addr
);
  tgt_e tgt;

  always_comb begin
    if (in_win)       tgt = TGT_SDRAM;
    else if (in_boot) tgt = remap ? TGT_RAM : TGT_ROM;
    else              tgt = TGT_PASS;
  end

  for (genvar g = 0; g < TGT_N; g++) begin : g_sel
    assign sel[g] = (int'(tgt) == g);
  end

  always_comb begin
    case (tgt)
      TGT_SDRAM: local_addr = addr - {start_hi, {GRAN_W{1'b0}}};
      TGT_ROM,
      TGT_RAM:   local_addr = {{HI_W{1'b0}}, addr[GRAN_W-1:0]};
      default:   local_addr = addr;
    endcase
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import remap_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20,
  parameter logic [ADDR_W-1:0] RST_START = 32'h0010_0001,
  parameter logic [ADDR_W-1:0] RST_END   = 32'hC000_0000,
  parameter logic RST_REMAP = 1'b0,
  localparam int HI_W = ADDR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic [ADDR_W-1:0] tgt_addr
);
  logic [HI_W-1:0] win_start_r, win_end_r;
  logic            filt_en_r, remap_r;
  logic            hit_win, hit_boot;

  remap_cfg_regs #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
    .RST_START(RST_START), .RST_END(RST_END), .RST_REMAP(RST_REMAP)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .start_hi(win_start_r), .filt_en(filt_en_r),
    .end_hi(win_end_r), .remap(remap_r)
  );

  remap_window_cmp #(.HI_W(HI_W)) u_cmp (
    .addr_hi(req_addr[ADDR_W-1:GRAN_W]), .start_hi(win_start_r),
    .end_hi(win_end_r), .filt_en(filt_en_r),
    .in_win(hit_win), .in_boot(hit_boot)
  );

  remap_target_sel #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_sel (
    .in_win(hit_win), .in_boot(hit_boot), .remap(remap_r),
    .addr(req_addr), .start_hi(win_start_r),
    .sel(tgt_sel), .local_addr(tgt_addr)
  );
endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20,
  localparam int HI_W = ADDR_W - GRAN_W
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        tgt_sel,
  input logic [HI_W-1:0]   win_start_r,
  input logic [HI_W-1:0]   win_end_r,
  input logic              filt_en_r,
  input logic              remap_r
);
  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tgt_sel) == 1);

  // R3
  remap_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2) |=> (remap_r == $past(reg_wdata[0])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_we || reg_addr == 2'd3) |=>
      ($stable(win_start_r) && $stable(win_end_r) && $stable(filt_en_r) && $stable(remap_r)));

  // R5
  no_sdram_off_chk: assert property (@(posedge clk) disable iff (rst)
    !filt_en_r |-> !tgt_sel[0]);

  // R7
  boot_to_sdram_chk: assert property (@(posedge clk) disable iff (rst)
    (req_addr[ADDR_W-1:GRAN_W] == '0 && filt_en_r && win_start_r == '0 && win_end_r != '0)
      |-> tgt_sel == 4'b0001);

  // R6
  boot_remap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_addr[ADDR_W-1:GRAN_W] == '0 && (!filt_en_r || win_start_r != '0 || win_end_r == '0))
      |-> tgt_sel == (remap_r ? 4'b0100 : 4'b0010));
endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .req_addr(req_addr), .tgt_sel(tgt_sel), .win_start_r(win_start_r),
  .win_end_r(win_end_r), .filt_en_r(filt_en_r), .remap_r(remap_r)
);

// File: tb/test_boot_remap_decoder.sv
module test_boot_remap_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] req_addr = '0;
  logic [3:0]  tgt_sel;
  logic [31:0] tgt_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // bench model of configuration
  logic [11:0] m_s = 12'h001, m_e = 12'hC00;
  logic        m_en = 1'b1, m_remap = 1'b0;

  boot_remap_decoder i_boot_remap_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
    .tgt_sel(tgt_sel), .tgt_addr(tgt_addr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [3:0] exp_sel(logic [31:0] a);
    logic [11:0] hi;
    hi = a[31:20];
    if (m_en && hi >= m_s && hi < m_e) return 4'b0001;
    else if (hi == 12'h0) return m_remap ? 4'b0100 : 4'b0010;
    else return 4'b1000;
  endfunction

  function automatic logic [31:0] exp_loc(logic [31:0] a);
    logic [3:0] s;
    s = exp_sel(a);
    if (s == 4'b0001) return a - {m_s, 20'h0};
    else if (s == 4'b1000) return a;
    else return {12'h0, a[19:0]};
  endfunction

  // full sweep: both ends of every granule
  task automatic sweep(string tag);
    int bad = 0;
    for (int g = 0; g < 4096; g++) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] a;
        a = {g[11:0], (k == 0) ? 20'h00000 : 20'hFFFFF};
        req_addr = a; #1;
        checks++;
        if (tgt_sel !== exp_sel(a) || tgt_addr !== exp_loc(a)) begin
          failures++;
          if (bad < 8)
            $display("FAIL %s addr=%h act=%h/%h exp=%h/%h", tag, a,
                     tgt_sel, tgt_addr, exp_sel(a), exp_loc(a));
          bad++;
        end
      end
    end
  endtask

  task automatic set_start(logic [11:0] s, logic en);
    wr(2'd0, {s, 19'h0, en}); m_s = s; m_en = en;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset values
    rd("R1 start reset", 2'd0, 32'h0010_0001);
    rd("R1 end reset",   2'd1, 32'hC000_0000);
    rd("R1 remap reset", 2'd2, 32'h0000_0000);
    // R10 unused offset reads zero
    rd("R10 offset3 read", 2'd3, 32'h0);

    // R4 R6 R8 R9 reset map: ROM at zero, SDRAM 1MB..3GB
    sweep("R4_R6_R8_R9 reset map");
    req_addr = 32'h0010_0000; #1;
    chk("R4 start inclusive", {28'h0, tgt_sel}, 32'h1);
    chk("R9 sdram local", tgt_addr, 32'h0);
    req_addr = 32'hBFFF_FFFF; #1;
    chk("R4 below end", {28'h0, tgt_sel}, 32'h1);
    req_addr = 32'hC000_0000; #1;
    chk("R4 end exclusive", {28'h0, tgt_sel}, 32'h8);

    // R3 remap write: old map before edge, new after
    req_addr = 32'h0000_1234;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hFFFF_FFFF;
    #1;
    chk("R3 before edge", {28'h0, tgt_sel}, 32'h2);
    @(posedge clk); #1;
    reg_we = 1'b0; m_remap = 1'b1;
    chk("R3 after edge", {28'h0, tgt_sel}, 32'h4);
    chk("R9 ram local", tgt_addr, 32'h0000_1234);
    rd("R2 remap masked", 2'd2, 32'h1);
    sweep("R6 remap ram");

    // R7 window over boot region overrides remap
    req_addr = 32'h0000_0040;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0001;
    #1;
    chk("R3 start before edge", {28'h0, tgt_sel}, 32'h4);
    @(posedge clk); #1;
    reg_we = 1'b0; m_s = 12'h000; m_en = 1'b1;
    chk("R7 boot to sdram", {28'h0, tgt_sel}, 32'h1);
    sweep("R7 sdram at zero");
    wr(2'd2, 32'h0); m_remap = 1'b0;
    sweep("R7 remap zero ignored");

    // R5 filter disabled
    set_start(12'h000, 1'b0);
    sweep("R5 filter off");

    // R10 write to offset 3 ignored
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R10 start kept", 2'd0, 32'h0);
    rd("R10 end kept", 2'd1, 32'hC000_0000);
    rd("R10 remap kept", 2'd2, 32'h0);
    sweep("R10 map unchanged");

    // R4 single-granule window high in space
    set_start(12'h800, 1'b1);
    wr(2'd1, 32'h8010_0000); m_e = 12'h801;
    sweep("R4 one granule");
    req_addr = 32'h800A_BCDE; #1;
    chk("R9 sdram offset", tgt_addr, 32'h000A_BCDE);

    // R4 empty and inverted windows
    set_start(12'h400, 1'b1);
    wr(2'd1, 32'h4000_0000); m_e = 12'h400;
    sweep("R4 empty window");
    wr(2'd1, 32'h2000_0000); m_e = 12'h200;
    sweep("R4 inverted window");

    // R2 reserved bits
    wr(2'd0, 32'hFFFF_FFFF); m_s = 12'hFFF; m_en = 1'b1;
    wr(2'd1, 32'hFFFF_FFFF); m_e = 12'hFFF;
    rd("R2 start masked", 2'd0, 32'hFFF0_0001);
    rd("R2 end masked",   2'd1, 32'hFFF0_0000);
    sweep("R4 top granule excluded");

    // R1 reset again restores
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    m_s = 12'h001; m_e = 12'hC00; m_en = 1'b1; m_remap = 1'b0;
    rd("R1 start after rst", 2'd0, 32'h0010_0001);
    req_addr = 32'h0000_0000; #1;
    chk("R1 rom at zero", {28'h0, tgt_sel}, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule